// File: doc/BRIEF.md
# Two-Step Key Access Controller

This block keeps the security level of a command-driven register interface. The level is sealed, unsealed or full access. Reset always leaves it sealed. A decoded command stream feeds it with a valid strobe, a 16-bit word and a flag. The flag separates key words from every other command code. To move up one level, two key words must arrive in order. Each upward step has its own pair of words. The second word must come within a window of one-second ticks, and no other command may come between the two words.

The register file beside this block takes the current level and three permit lines from it. It uses them to refuse reads of diagnostics while sealed. It also uses them to limit scratchpad writes and all key-register access to full access. The four key words live in registers inside the block. A simple select/data port reads and writes them, and that port works only in full access. A dedicated seal command code returns the block to sealed from any level.

Top module: `keygate_ctrl`

## Requirements
- R1: After reset the level output is sealed (code 2'b00), all three permit outputs are 0 and `key_rdata` is 0. The level output never shows code 2'b11.
- R2: While sealed, a key word equal to unseal word A followed by a key word equal to unseal word B raises the level to unsealed (code 2'b01). The new level shows in the cycle after the word-B command.
- R3: While unsealed, full-access word A followed by full-access word B raises the level to full access (code 2'b10). The unseal words have no effect while unsealed.
- R4: After a first word, ticks of `tick_1s` that arrive in cycles with no command are counted. The fifth such tick drops the attempt. A second word is accepted after zero to four ticks. It is also accepted in the same cycle as the tick that would be the fifth, because the command takes precedence over that tick.
- R5: Any non-key command (valid with `cmd_is_key`=0) cancels a pending attempt. A later second word then does not change the level.
- R6: A key word that arrives while an attempt is pending and does not match the expected second word drops the attempt and leaves the level unchanged. That key word does not itself start a new attempt.
- R7: A non-key command with word `SEAL_CODE` (default 16'h0030) sets the level to sealed in the next cycle, from any level.
- R8: Key registers (select 0 = unseal A, 1 = unseal B, 2 = full A, 3 = full B) are written by `key_wr` only in full access. Outside full access `key_rdata` reads 0 and writes are dropped.
- R9: `perm_diag_rd` is 1 while unsealed or in full access. `perm_scratch_wr` and `perm_key_rw` are 1 only in full access.
- R10: Key words received in full access leave the level at full access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_vld | input | 1 | Command event strobe |
| cmd_is_key | input | 1 | 1: word is a key word; 0: word is a command code |
| cmd_word | input | 16 | Key word or command code |
| tick_1s | input | 1 | One-cycle pulse per second |
| key_wr | input | 1 | Key register write strobe |
| key_sel | input | 2 | Key register select |
| key_wdata | input | 16 | Key register write data |
| key_rdata | output | 16 | Selected key register, 0 outside full access |
| level | output | 2 | 00 sealed, 01 unsealed, 10 full access |
| perm_diag_rd | output | 1 | Diagnostic reads permitted |
| perm_scratch_wr | output | 1 | Scratchpad writes permitted |
| perm_key_rw | output | 1 | Key register access permitted |

## Verification
A window tick and a command can land in the same cycle, and which one wins decides whether the attempt survives. The bench raises `tick_1s` together with the second key word after four earlier ticks. It expects the step up, because the command is resolved first. The same sweep also runs zero to six ticks before the second word, and the expected level is computed as accepted exactly when fewer than five ticks were counted.

// File: rtl/keygate_ctrl.sv
module keygate_ctrl #(
  parameter int          KW        = 16,
  parameter int          WIN_TICKS = 5,
  parameter logic [15:0] SEAL_CODE = 16'h0030,
  parameter logic [15:0] UNS_A     = 16'h0414,
  parameter logic [15:0] UNS_B     = 16'h3672,
  parameter logic [15:0] FUL_A     = 16'hA5C3,
  parameter logic [15:0] FUL_B     = 16'h5A3C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_vld,
  input  logic          cmd_is_key,
  input  logic [KW-1:0] cmd_word,
  input  logic          tick_1s,
  input  logic          key_wr,
  input  logic [1:0]    key_sel,
  input  logic [KW-1:0] key_wdata,
  output logic [KW-1:0] key_rdata,
  output logic [1:0]    level,
  output logic          perm_diag_rd,
  output logic          perm_scratch_wr,
  output logic          perm_key_rw
);
  localparam int CW = $clog2(WIN_TICKS + 1);
  localparam logic [1:0] LV_SEALED = 2'b00;
  localparam logic [1:0] LV_UNSEAL = 2'b01;
  localparam logic [1:0] LV_FULL   = 2'b10;

  logic [3:0][KW-1:0] key_q;
  logic               pend;
  logic [CW-1:0]      win_cnt;

  wire is_full  = (level == LV_FULL);
  wire [KW-1:0] want_a = (level == LV_SEALED) ? key_q[0] : key_q[2];
  wire [KW-1:0] want_b = (level == LV_SEALED) ? key_q[1] : key_q[3];

  assign perm_key_rw     = is_full;
  assign perm_scratch_wr = is_full;
  assign perm_diag_rd    = (level != LV_SEALED);
  assign key_rdata       = is_full ? key_q[key_sel] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= {FUL_B[KW-1:0], FUL_A[KW-1:0], UNS_B[KW-1:0], UNS_A[KW-1:0]};
    end else if (key_wr && is_full) begin
      key_q[key_sel] <= key_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level   <= LV_SEALED;
      pend    <= 1'b0;
      win_cnt <= '0;
    end else if (cmd_vld) begin
      pend    <= 1'b0;
      win_cnt <= '0;
      if (!cmd_is_key) begin
        if (cmd_word == SEAL_CODE[KW-1:0]) level <= LV_SEALED;
      end else if (!is_full) begin
        if (pend) begin
          if (cmd_word == want_b)
            level <= (level == LV_SEALED) ? LV_UNSEAL : LV_FULL;
        end else if (cmd_word == want_a) begin
          pend <= 1'b1;
        end
      end
    end else if (tick_1s && pend) begin
      if (win_cnt == CW'(WIN_TICKS - 1)) begin
        pend    <= 1'b0;
        win_cnt <= '0;
      end else begin
        win_cnt <= win_cnt + 1'b1;
      end
    end
  end
endmodule

module keygate_ctrl_chk #(
  parameter int          KW        = 16,
  parameter int          WIN_TICKS = 5,
  parameter logic [15:0] SEAL_CODE = 16'h0030,
  parameter int          CW        = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_vld,
  input logic               cmd_is_key,
  input logic [KW-1:0]      cmd_word,
  input logic [1:0]         level,
  input logic               pend,
  input logic [CW-1:0]      win_cnt,
  input logic [3:0][KW-1:0] key_q
);
  assert_level_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    level != 2'b11);

  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (level != $past(level) && level != 2'b00) |->
      ($past(cmd_vld && cmd_is_key) && level == $past(level) + 2'd1));

  assert_window_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> (int'(win_cnt) < WIN_TICKS));

  assert_cancel_on_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && !cmd_is_key) |=> !pend);

  assert_seal_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && !cmd_is_key && cmd_word == SEAL_CODE[KW-1:0]) |=> level == 2'b00);

  assert_keys_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (level != 2'b10) |=> $stable(key_q));

  assert_full_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (level == 2'b10 && !(cmd_vld && !cmd_is_key && cmd_word == SEAL_CODE[KW-1:0]))
      |=> level == 2'b10);
endmodule

bind keygate_ctrl keygate_ctrl_chk #(
  .KW(KW), .WIN_TICKS(WIN_TICKS), .SEAL_CODE(SEAL_CODE), .CW(CW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_is_key(cmd_is_key),
  .cmd_word(cmd_word), .level(level), .pend(pend), .win_cnt(win_cnt),
  .key_q(key_q)
);

// File: tb/keygate_ctrl_tb.sv
module keygate_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] SEAL = 16'h0030;
  localparam logic [15:0] UA = 16'h0414, UB = 16'h3672;
  localparam logic [15:0] FA = 16'hA5C3, FB = 16'h5A3C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_vld = 0, cmd_is_key = 0, tick_1s = 0, key_wr = 0;
  logic [15:0] cmd_word = '0, key_wdata = '0, key_rdata;
  logic [1:0] key_sel = '0, level;
  logic perm_diag_rd, perm_scratch_wr, perm_key_rw;
  int checks = 0, failures = 0;
  logic [15:0] nk [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  keygate_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_is_key(cmd_is_key),
    .cmd_word(cmd_word), .tick_1s(tick_1s), .key_wr(key_wr), .key_sel(key_sel),
    .key_wdata(key_wdata), .key_rdata(key_rdata), .level(level),
    .perm_diag_rd(perm_diag_rd), .perm_scratch_wr(perm_scratch_wr),
    .perm_key_rw(perm_key_rw)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic step(input logic v, input logic k, input logic [15:0] w, input logic t);
    cmd_vld = v; cmd_is_key = k; cmd_word = w; tick_1s = t;
    @(posedge clk); @(negedge clk);
    cmd_vld = 0; cmd_is_key = 0; tick_1s = 0;
  endtask

  task automatic key(input logic [15:0] w);  step(1, 1, w, 0); endtask
  task automatic other(input logic [15:0] w); step(1, 0, w, 0); endtask
  task automatic tick();                     step(0, 0, 16'h0, 1); endtask

  task automatic kwrite(input logic [1:0] s, input logic [15:0] d);
    key_wr = 1; key_sel = s; key_wdata = d;
    @(posedge clk); @(negedge clk);
    key_wr = 0;
  endtask

  task automatic perms(input string req, input logic [1:0] lv);
    chk(req, level, lv);
    chk(req, perm_diag_rd, lv != 2'b00);
    chk(req, perm_scratch_wr, lv == 2'b10);
    chk(req, perm_key_rw, lv == 2'b10);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    perms("R1", 2'b00);
    chk("R1", key_rdata, 16'h0);
    rst_n = 1;
    @(negedge clk);
    // R8: write attempt while sealed must be dropped
    kwrite(2'd0, 16'h1111);
    chk("R8", key_rdata, 16'h0);

    // R4 sweep: 0..6 ticks between the two words
    for (int n = 0; n <= 6; n++) begin
      other(SEAL);
      key(UA);
      for (int t = 0; t < n; t++) tick();
      key(UB);
      chk("R4", level, (n < 5) ? 2'b01 : 2'b00);
    end
    // R4: second word coinciding with the fifth tick is accepted
    other(SEAL);
    key(UA);
    for (int t = 0; t < 4; t++) tick();
    step(1, 1, UB, 1);
    chk("R4", level, 2'b01);
    perms("R9", 2'b01);
    chk("R8", key_rdata, 16'h0);
    // R4: tick in same cycle as first word is not counted
    other(SEAL);
    step(1, 1, UA, 1);
    for (int t = 0; t < 4; t++) tick();
    key(UB);
    chk("R4", level, 2'b01);

    // R5 intervening command cancels
    other(SEAL);
    key(UA); other(16'h1234); key(UB);
    chk("R5", level, 2'b00);

    // R6 mismatch drops and does not restart
    key(UA); key(UA); key(UB);
    chk("R6", level, 2'b00);
    key(UA); key(16'hBEEF);
    chk("R6", level, 2'b00);
    key(UA); key(UB);
    chk("R2", level, 2'b01);

    // R3: unseal words have no effect while unsealed, full words step up
    key(UA); key(UB);
    chk("R3", level, 2'b01);
    key(FA); key(FB);
    chk("R3", level, 2'b10);
    perms("R9", 2'b10);

    // R10 key words in full access ignored
    key(FA); key(FB); key(UA); key(UB); key(16'h0000);
    chk("R10", level, 2'b10);

    // R8: default keys readable and all rewritable in full access
    key_sel = 2'd0; @(negedge clk); chk("R8", key_rdata, UA);
    key_sel = 2'd3; @(negedge clk); chk("R8", key_rdata, FB);
    for (int s = 0; s < 4; s++) begin
      nk[s] = 16'h1000 * (s + 1) + 16'h0055 * s + 16'h0007;
      kwrite(2'(s), nk[s]);
    end
    for (int s = 0; s < 4; s++) begin
      key_sel = 2'(s); @(negedge clk);
      chk("R8", key_rdata, nk[s]);
    end

    // R7 seal from full access
    other(SEAL);
    perms("R7", 2'b00);
    chk("R8", key_rdata, 16'h0);
    // old keys now rejected, new keys accepted
    key(UA); key(UB);
    chk("R8", level, 2'b00);
    key(nk[0]); key(nk[1]);
    chk("R2", level, 2'b01);
    // R7 seal from unsealed, non-seal code leaves level
    other(16'h0031);
    chk("R7", level, 2'b01);
    other(SEAL);
    chk("R7", level, 2'b00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule